// File: doc/BRIEF.md
# Self-Repairing SRAM Wrapper with Address Remapping

The block holds a 32-word by 12-bit on-chip memory behind a small test-and-repair controller. A mode input chooses who drives the memory. In normal mode, the external address, write data and enables reach the array through multiplexers. In test mode, the controller owns the array. It visits each physical word in turn. It writes all zeros and reads them back, then writes all ones and reads them back. Any word that returns the wrong value is marked as bad.

Once the sweep ends, the controller scans the mark vector. It fills a remap table so that logical address k points at the k-th good physical word. No spare rows or columns exist, so the usable capacity is 32 minus the number of bad words, and this count is reported on a port. A normal access whose logical address is at or beyond that count has no effect on the memory, and a read at such an address returns zero. The sweep ends early once the number of marked words reaches a parameter limit.

For verification, the array model accepts a parameter mask of defective words. In each defective word one chosen bit is stuck at 0 on every read.

Top module: `sram_remap_repair`

## Requirements
- R1: After reset, err, test_done and rdata are 0 and usable is 32. Logical addresses map one-to-one onto the same physical word.
- R2: With test_mode at 0, wr_en writes wdata and rd_en reads at the remapped address. With test_mode at 1, external writes and reads have no effect: memory contents and rdata are unchanged. test_start is acted on only while test_mode is 1 and no test is running.
- R3: A normal read presents the data on rdata one clock after the cycle rd_en is sampled. rdata holds its value until the next normal read.
- R4: For each physical address from 0 upward, the controller writes 0x000, reads the word and compares it. It then writes 0xFFF, reads the word and compares it. A word that fails the zero check is not given the ones check.
- R5: On a compare mismatch, err is set and stays set until the next test start. err_addr takes the failing physical address, and that address is marked bad.
- R6: The sweep stops after physical address 31, or as soon as the number of marked words reaches MAX_MARKS, whichever comes first. Addresses left unvisited are not marked.
- R7: After a test, logical address k maps to the k-th unmarked physical address, counting from 0. usable equals 32 minus the number of marked words.
- R8: A normal write at a logical address of usable or above leaves every word unchanged. A normal read at such an address returns 0x000.
- R9: test_done rises when the remap table is complete and stays high until reset or a new test start. A new test start clears err, test_done, the marks and usable (usable reads 0 while the test runs).
- R10: In the array model, a word whose index bit is set in FAULT_WORDS returns bit FAULT_BIT as 0 on every read. All other bits behave normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode | input | 1 | 1 selects test mode, 0 selects normal mode |
| test_start | input | 1 | Starts a test-and-repair sweep (test mode only) |
| addr | input | 5 | Logical address for normal access |
| wdata | input | 12 | Normal write data |
| wr_en | input | 1 | Normal write enable |
| rd_en | input | 1 | Normal read enable |
| rdata | output | 12 | Normal read data, one cycle after rd_en |
| err | output | 1 | Sticky mismatch flag of the current test |
| err_addr | output | 5 | Most recent failing physical address |
| test_done | output | 1 | Test and remap finished |
| usable | output | 6 | Number of usable logical words |

## Verification
Two events can land in the same cycle: marking a failing word, and ending the sweep. This happens when the final physical address fails, or when a mismatch brings the mark count up to MAX_MARKS. The bench provokes the first case by placing a defect at address 31. It provokes the second with a second instance whose limit is smaller than the number of defects. In both cases it checks that err_addr, the usable count and the resulting logical-to-physical mapping match a model. In that model, the final mark is both recorded and counted before the sweep stops.

// File: rtl/sram_remap_repair.sv
module sram_remap_repair #(
  parameter int DEPTH       = 32,
  parameter int WIDTH       = 12,
  parameter int MAX_MARKS   = 8,
  parameter logic [DEPTH-1:0] FAULT_WORDS = '0,
  parameter int FAULT_BIT   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          test_mode,
  input  logic                          test_start,
  input  logic [$clog2(DEPTH)-1:0]      addr,
  input  logic [WIDTH-1:0]              wdata,
  input  logic                          wr_en,
  input  logic                          rd_en,
  output logic [WIDTH-1:0]              rdata,
  output logic                          err,
  output logic [$clog2(DEPTH)-1:0]      err_addr,
  output logic                          test_done,
  output logic [$clog2(DEPTH+1)-1:0]    usable
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [WIDTH-1:0] STUCK = WIDTH'(1) << FAULT_BIT;

  typedef enum logic [2:0] {S_IDLE, S_W0, S_R0, S_C0, S_W1, S_R1, S_C1, S_BUILD} st_t;

  st_t              st;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    remap [DEPTH];
  logic [DEPTH-1:0] marks;
  logic [CW-1:0]    mcnt, bcnt;
  logic [AW-1:0]    caddr, bp;
  logic [WIDTH-1:0] mem_q;

  logic [AW-1:0]    phys, mem_wa;
  logic [WIDTH-1:0] rd_norm, rd_test, mem_wd;
  logic             in_rng, ctl_we, mem_we, start_ok, fail, last;

  assign phys     = remap[addr];
  assign in_rng   = {1'b0, addr} < usable;
  assign rd_norm  = mem[phys]  & ~(FAULT_WORDS[phys]  ? STUCK : '0);
  assign rd_test  = mem[caddr] & ~(FAULT_WORDS[caddr] ? STUCK : '0);
  assign ctl_we   = (st == S_W0) || (st == S_W1);
  assign mem_we   = test_mode ? ctl_we : (wr_en && in_rng);
  assign mem_wa   = test_mode ? caddr : phys;
  assign mem_wd   = test_mode ? ((st == S_W1) ? '1 : '0) : wdata;
  assign start_ok = test_mode && test_start && (st == S_IDLE);
  assign fail     = ((st == S_C0) && (mem_q != '0)) || ((st == S_C1) && (mem_q != '1));
  assign last     = (caddr == AW'(DEPTH-1)) || (fail && (mcnt + CW'(1) == CW'(MAX_MARKS)));

  always_ff @(posedge clk)
    if (mem_we) mem[mem_wa] <= mem_wd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 rdata <= '0;
    else if (!test_mode && rd_en) rdata <= in_rng ? rd_norm : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  caddr <= '0;  bp <= '0;  bcnt <= '0;
      marks <= '0;   mcnt <= '0;   mem_q <= '0;
      err <= 1'b0;   err_addr <= '0;  test_done <= 1'b0;
      usable <= CW'(DEPTH);
      for (int i = 0; i < DEPTH; i++) remap[i] <= AW'(i);
    end else begin
      case (st)
        S_IDLE: if (start_ok) begin
          marks <= '0; mcnt <= '0; err <= 1'b0; test_done <= 1'b0;
          usable <= '0; caddr <= '0; st <= S_W0;
        end
        S_W0: st <= S_R0;
        S_W1: st <= S_R1;
        S_R0: begin mem_q <= rd_test; st <= S_C0; end
        S_R1: begin mem_q <= rd_test; st <= S_C1; end
        S_C0, S_C1: begin
          if (fail) begin
            marks[caddr] <= 1'b1;
            mcnt         <= mcnt + CW'(1);
            err          <= 1'b1;
            err_addr     <= caddr;
          end
          if (!fail && st == S_C0) st <= S_W1;
          else if (last) begin
            st <= S_BUILD; bp <= '0; bcnt <= '0;
          end else begin
            caddr <= caddr + AW'(1); st <= S_W0;
          end
        end
        S_BUILD: begin
          if (!marks[bp]) begin
            remap[bcnt[AW-1:0]] <= bp;
            bcnt <= bcnt + CW'(1);
          end
          if (bp == AW'(DEPTH-1)) begin
            usable    <= bcnt + CW'(!marks[bp]);
            test_done <= 1'b1;
            st        <= S_IDLE;
          end else bp <= bp + AW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_TEST_RDATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> $stable(rdata)); // R2
  AST_ERR_ADDR_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> marks[err_addr]); // R5
  AST_MARK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    mcnt <= CW'(MAX_MARKS)); // R6
  AST_USABLE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |-> (usable == CW'(DEPTH) - mcnt)); // R7
  AST_REMAP_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    (test_done && in_rng) |-> !marks[phys]); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (test_done && !(test_mode && test_start)) |=> test_done); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (!err && !test_done && marks == '0)); // R9
endmodule

// File: tb/test_sram_remap_repair.sv
`timescale 1ns/1ps
module test_sram_remap_repair;
  localparam int DEPTH = 32;
  localparam logic [31:0] FAULTS = 32'h8000_0061; // words 0,5,6,31
  localparam int FBIT = 3;
  localparam int MAXM = 8;
  localparam int MAXL = 2;

  logic clk = 0, rst_n = 0;
  logic test_mode = 0, test_start = 0, wr_en = 0, rd_en = 0;
  logic [4:0] addr = 0;
  logic [11:0] wdata = 0;
  logic [11:0] rdata, rdata_l;
  logic err, err_l, done, done_l;
  logic [4:0] err_addr, err_addr_l;
  logic [5:0] usable, usable_l;
  int tests = 0, fails = 0;
  logic [11:0] model [32];

  always #2 clk = ~clk;

  sram_remap_repair #(.MAX_MARKS(MAXM), .FAULT_WORDS(FAULTS), .FAULT_BIT(FBIT)) i_sram_remap_repair (
    .clk, .rst_n, .test_mode, .test_start, .addr, .wdata, .wr_en, .rd_en,
    .rdata, .err, .err_addr, .test_done(done), .usable);

  sram_remap_repair #(.MAX_MARKS(MAXL), .FAULT_WORDS(FAULTS), .FAULT_BIT(FBIT)) i_sram_remap_repair_lim (
    .clk, .rst_n, .test_mode, .test_start, .addr, .wdata, .wr_en, .rd_en,
    .rdata(rdata_l), .err(err_l), .err_addr(err_addr_l), .test_done(done_l), .usable(usable_l));

  function automatic logic [31:0] exp_marks(int maxm);
    logic [31:0] m = '0; int c = 0;
    for (int p = 0; p < DEPTH; p++) begin
      if (FAULTS[p]) begin m[p] = 1'b1; c++; end
      if (c == maxm) break;
    end
    return m;
  endfunction

  function automatic int exp_last(int maxm);
    logic [31:0] m = exp_marks(maxm); int l = 0;
    for (int p = 0; p < DEPTH; p++) if (m[p]) l = p;
    return l;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [11:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [11:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic run_test;
    @(negedge clk); test_mode = 1; test_start = 1;
    @(negedge clk); test_start = 0;
    chk("R9 start clears err", err, 0);
    chk("R9 start clears done", done, 0);
    chk("R9 usable zero while running", usable, 0);
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    test_mode = 0;
  endtask

  task automatic check_results;
    int u = DEPTH - $countones(exp_marks(MAXM));
    chk("R9 done main", done, 1);
    chk("R5 err main", err, 1);
    chk("R5 R6 err_addr last fail at 31", err_addr, exp_last(MAXM));
    chk("R7 usable main", usable, u);
    chk("R6 R9 done lim", done_l, 1);
    chk("R6 err_addr lim", err_addr_l, exp_last(MAXL));
    chk("R6 R7 usable lim", usable_l, DEPTH - MAXL);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [11:0] d;
    int u;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    chk("R1 err", err, 0);
    chk("R1 done", done, 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 usable", usable, 32);
    rst_n = 1;
    @(negedge clk);
    test_start = 1; @(negedge clk); test_start = 0;
    repeat (5) @(negedge clk);
    chk("R2 start ignored in normal mode", done, 0);
    chk("R2 usable unchanged", usable, 32);

    wr(1, 12'hABC); rd(1, d);
    chk("R1 R3 identity read", d, 12'hABC);
    wr(5, 12'hABC); rd(5, d);
    chk("R10 stuck bit on faulty word 5", d, 12'hAB4);
    @(negedge clk); test_mode = 1;
    wr(1, 12'h111);
    @(negedge clk); addr = 5; rd_en = 1; @(negedge clk); rd_en = 0;
    chk("R2 read ignored in test mode", rdata, 12'hAB4);
    test_mode = 0;
    rd(1, d);
    chk("R2 write ignored in test mode", d, 12'hABC);

    run_test();
    check_results();

    u = usable;
    for (int k = 0; k < u; k++) begin
      model[k] = 12'($urandom) | 12'h008 | 12'(k << 4);
      wr(5'(k), model[k]);
    end
    for (int k = 0; k < u; k++) begin
      rd(5'(k), d);
      chk("R7 remap skips bad words", d, model[k]);
    end
    wr(5'(u), 12'hFFF); rd(5'(u), d);
    chk("R8 out of range read zero", d, 0);
    rd(31, d);
    chk("R8 read at 31 zero", d, 0);
    rd(5'(u-1), d);
    chk("R8 out of range write no effect", d, model[u-1]);

    for (int n = 0; n < 400; n++) begin
      logic [4:0] a = 5'($urandom % 32);
      if ($urandom % 2) begin
        logic [11:0] v = 12'($urandom) | 12'h008;
        wr(a, v);
        if (a < u) model[a] = v;
      end else begin
        rd(a, d);
        chk("R7 R8 random access", d, (a < u) ? model[a] : 12'h000);
      end
    end

    run_test();
    check_results();
    rd(0, d);
    chk("R4 word left at all ones", d, 12'hFFF);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule